// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous static RAM. Its word is split into byte lanes. Address, chip select, direction, burst advance and lane write enables are registered on the rising clock edge. Write data trails its command by exactly one clock and passes through an internal pending stage. Because of this, a read can follow a write, and a write can follow a read, on consecutive clocks with no idle cycle between them.

Read data flows through combinationally from the array, or from the pending write, in the cycle right after the read command is registered. No output register sits in that path. Bursts of up to four words come from an internal two-bit counter that steps only when the advance input is high. A static select picks linear or interleaved order.

The output is gated asynchronously by the output enable and by the sleep input. A high-impedance bus is represented by `q_drive` low with `q_data` forced to zero. The bus has no back-pressure: a command is taken on every clock that is not asleep, and write data must arrive on the clock after its command.

Top module: `zbt_sram`

## Requirements
- R1: After reset, `q_drive` is 0 and `q_data` is 0 until a read command is registered.
- R2: A read command (`cs`=1, `wr`=0, `adv`=0) registered on an edge puts the addressed word on `q_data` with `q_drive`=1 during the cycle that edge begins.
- R3: For a write command registered on edge n, `d_data` is sampled on edge n+1. A later read of that address returns the written data.
- R4: On a write, lane i, which is bits [8i+7:8i] for the default lane width of 8, changes only when `lane_we[i]`=1. Disabled lanes keep their old contents.
- R5: A read whose address matches a write still pending in the pipeline returns the new bytes for enabled lanes and the array bytes for the others.
- R6: Reads and writes may alternate on every clock with no idle cycle. Every read returns the most recent data written to its address.
- R7: With `ilv`=0, each `adv`=1 cycle after an active cycle continues the burst with the same direction. The low two address bits are start+count modulo 4, and the upper bits are unchanged.
- R8: With `ilv`=1, the burst's low two address bits are the start bits XOR the count.
- R9: `adv`=1 takes priority over `cs`. When the previous cycle was not active, an `adv`=1 cycle is idle even if `cs`=1.
- R10: When an edge samples `cs`=0 and `adv`=0, `q_drive` is 0 for the cycle that follows.
- R11: `oe`=0 forces `q_drive`=0 and `q_data`=0 immediately, without waiting for a clock.
- R12: When an edge samples `sleep`=1, the command on that edge is ignored: a write there changes no memory. While `sleep`=1, `q_drive` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, registered |
| wr | input | 1 | 1 = write, 0 = read, registered |
| adv | input | 1 | Burst advance, registered |
| lane_we | input | LANES | Per-lane write enables, registered |
| addr | input | ADDR_W | Word address, registered |
| d_data | input | LANES*LANE_W | Write data, one clock after its command |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep: blocks new commands, turns output off |
| ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| q_data | output | LANES*LANE_W | Read data, zero when not driven |
| q_drive | output | 1 | High when the bus is driven |

## Verification
A wrong burst counter or a wrong order select returns another word within the burst on the very next advance cycle. A stale or mis-merged pending write shows on the read that directly follows it, as wrong bytes in exactly the lanes that were enabled or disabled. A stuck command-valid bit shows as `q_drive` high on the cycle after a deselect or sleep edge. A lost write shows only on a later read of that address, so every write in the bench is read back.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BURST_W = 2;

  // Low address bits of burst beat `cnt`, starting at `start`.
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] cnt,
    input logic               interleave
  );
    if (interleave) return start ^ cnt;
    else            return start + cnt;
  endfunction
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              adv,
  input  logic              sleep,
  input  logic              ilv,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  output logic              cur_v,
  output logic              cur_w,
  output logic [LANES-1:0]  cur_be,
  output logic [ADDR_W-1:0] cur_addr
);
  import zbt_pkg::*;

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v  <= 1'b0;
      cur_w  <= 1'b0;
      cur_be <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (sleep) begin
      cur_v <= 1'b0;
    end else if (adv) begin
      if (cur_v) begin
        cnt_q  <= cnt_q + 1'b1;
        cur_be <= lane_we;
      end else begin
        cur_v <= 1'b0;
      end
    end else if (cs) begin
      cur_v  <= 1'b1;
      cur_w  <= wr;
      cur_be <= lane_we;
      base_q <= addr;
      cnt_q  <= '0;
    end else begin
      cur_v <= 1'b0;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:BURST_W], burst_lo(base_q[BURST_W-1:0], cnt_q, ilv)};
endmodule

// File: rtl/zbt_wpipe.sv
module zbt_wpipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_wr,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LANES-1:0]        cmd_be,
  input  logic [LANES*LANE_W-1:0] d_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] arr_data,
  output logic                    pend_v,
  output logic [ADDR_W-1:0]       pend_addr,
  output logic [LANES-1:0]        pend_be,
  output logic [LANES*LANE_W-1:0] pend_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_be   <= '0;
      pend_data <= '0;
    end else begin
      pend_v <= cmd_wr;
      if (cmd_wr) begin
        pend_addr <= cmd_addr;
        pend_be   <= cmd_be;
        pend_data <= d_data;
      end
    end
  end

  logic hit;
  assign hit = pend_v && (pend_addr == rd_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_merge
    assign rd_data[i*LANE_W +: LANE_W] = (hit && pend_be[i]) ?
      pend_data[i*LANE_W +: LANE_W] : arr_data[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wen,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wen && wbe[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
    end
    assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs,
  input  logic                    wr,
  input  logic                    adv,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] d_data,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic                    ilv,
  output logic [LANES*LANE_W-1:0] q_data,
  output logic                    q_drive
);
  localparam int DW = LANES * LANE_W;

  logic              cur_v, cur_w;
  logic [LANES-1:0]  cur_be;
  logic [ADDR_W-1:0] cur_addr;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_be;
  logic [DW-1:0]     pend_data, arr_q, merged;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .adv(adv), .sleep(sleep),
    .ilv(ilv), .lane_we(lane_we), .addr(addr),
    .cur_v(cur_v), .cur_w(cur_w), .cur_be(cur_be), .cur_addr(cur_addr)
  );

  zbt_wpipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wpipe (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cur_v && cur_w), .cmd_addr(cur_addr),
    .cmd_be(cur_be), .d_data(d_data), .rd_addr(cur_addr), .arr_data(arr_q),
    .pend_v(pend_v), .pend_addr(pend_addr), .pend_be(pend_be),
    .pend_data(pend_data), .rd_data(merged)
  );

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wen(pend_v), .waddr(pend_addr), .wbe(pend_be),
    .wdata(pend_data), .raddr(cur_addr), .rdata(arr_q)
  );

  assign q_drive = oe && cur_v && !cur_w && !sleep;
  assign q_data  = q_drive ? merged : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic wr,
  input logic adv,
  input logic oe,
  input logic sleep,
  input logic q_drive,
  input logic cur_v,
  input logic cur_w,
  input logic pend_v
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !adv) |=> !q_drive); // R10
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !q_drive); // R11
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !q_drive); // R12
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !cur_v); // R12
  AST_WR_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_v && cur_w) |=> pend_v); // R3
  AST_READ_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !wr && !adv && !sleep) |=> (q_drive == (oe && !sleep))); // R2
  AST_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cur_v) |=> !cur_v); // R9
endmodule

bind zbt_sram zbt_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .adv(adv), .oe(oe),
  .sleep(sleep), .q_drive(q_drive), .cur_v(cur_v), .cur_w(cur_w),
  .pend_v(pend_v)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
  localparam int AW = 6;
  localparam int L  = 4;
  localparam int LW = 8;
  localparam int DW = L * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, wr = 1'b0, adv = 1'b0, oe = 1'b1, sleep = 1'b0, ilv = 1'b0;
  logic [L-1:0]  lane_we = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_data = '0;
  logic [DW-1:0] q_data;
  logic          q_drive;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] model [1 << AW];
  logic          pw_v = 1'b0;
  logic [AW-1:0] pw_addr = '0;
  logic [L-1:0]  pw_be = '0;

  always #5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .adv(adv), .lane_we(lane_we),
    .addr(addr), .d_data(d_data), .oe(oe), .sleep(sleep), .ilv(ilv),
    .q_data(q_data), .q_drive(q_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual {drive,data}=%h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return {8'(i), 8'(i ^ 8'h5A), 8'(~i), 8'(i + 3)};
  endfunction

  // One bus cycle. kind: 0 idle, 1 read, 2 write. wd is the data for the previous write.
  task automatic step(input logic c, w, a, sl, input logic [L-1:0] be,
                      input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                      input int kind, input logic [AW-1:0] ea, input string req);
    cs = c; wr = w; adv = a; sleep = sl; lane_we = be; addr = ad; d_data = wd;
    @(posedge clk);
    if (pw_v) begin
      for (int i = 0; i < L; i++)
        if (pw_be[i]) model[pw_addr][i*LW +: LW] = wd[i*LW +: LW];
    end
    pw_v = (kind == 2); pw_addr = ea; pw_be = be;
    @(negedge clk);
    if (kind == 1)
      chk(q_drive === 1'b1 && q_data === model[ea], req, {q_drive, q_data}, {1'b1, model[ea]});
    else
      chk(q_drive === 1'b0 && q_data === '0, req, {q_drive, q_data}, '0);
  endtask

  task automatic t_reset;
    chk(q_drive === 1'b0 && q_data === '0, "R1 reset", {q_drive, q_data}, '0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++)
      step(1, 1, 0, 0, '1, AW'(i), (i == 0) ? '0 : pat(i - 1), 2, AW'(i), "R3 fill");
    step(0, 0, 0, 0, '0, '0, pat(15), 0, '0, "R3 fill end");
    for (int i = 0; i < 16; i++)
      step(1, 0, 0, 0, '0, AW'(i), '0, 1, AW'(i), "R3/R2 readback");
  endtask

  task automatic t_lanes_bypass;
    step(1, 1, 0, 0, 4'b0101, 6'd2, '0, 2, 6'd2, "R4 lane write");
    step(1, 0, 0, 0, '0, 6'd2, 32'hAABBCCDD, 1, 6'd2, "R5 R4 pending merge");
    step(1, 0, 0, 0, '0, 6'd2, '0, 1, 6'd2, "R4 committed lanes");
  endtask

  task automatic t_turnaround;
    step(1, 1, 0, 0, '1, 6'd20, '0, 2, 6'd20, "R6 W");
    step(1, 0, 0, 0, '0, 6'd3, 32'h11112222, 1, 6'd3, "R6 R after W");
    step(1, 1, 0, 0, '1, 6'd21, '0, 2, 6'd21, "R6 W after R");
    step(1, 0, 0, 0, '0, 6'd20, 32'h33334444, 1, 6'd20, "R6 R committed");
    step(1, 0, 0, 0, '0, 6'd21, '0, 1, 6'd21, "R6 R latest");
    step(1, 1, 0, 0, 4'b1000, 6'd21, '0, 2, 6'd21, "R6 W lane3");
    step(1, 1, 0, 0, '1, 6'd22, 32'h99000000, 2, 6'd22, "R6 W W");
    step(1, 0, 0, 0, '0, 6'd21, 32'h55667788, 1, 6'd21, "R6 R older W");
    step(1, 0, 0, 0, '0, 6'd22, '0, 1, 6'd22, "R6 R newest W");
  endtask

  task automatic t_bursts;
    ilv = 0;
    step(1, 0, 0, 0, '0, 6'd6, '0, 1, 6'd6, "R7 linear beat0");
    step(0, 0, 1, 0, '0, '0, '0, 1, 6'd7, "R7 linear beat1");
    step(0, 0, 1, 0, '0, '0, '0, 1, 6'd4, "R7 linear wrap");
    step(1, 1, 1, 0, '0, 6'd33, '0, 1, 6'd5, "R7 R9 adv over cs");
    ilv = 1;
    step(1, 0, 0, 0, '0, 6'd9, '0, 1, 6'd9, "R8 ilv beat0");
    step(0, 0, 1, 0, '0, '0, '0, 1, 6'd8, "R8 ilv beat1");
    step(0, 0, 1, 0, '0, '0, '0, 1, 6'd11, "R8 ilv beat2");
    step(0, 0, 1, 0, '0, '0, '0, 1, 6'd10, "R8 ilv beat3");
    step(1, 1, 0, 0, 4'b0011, 6'd13, '0, 2, 6'd13, "R8 ilv wr beat0");
    step(0, 0, 1, 0, 4'b1100, '0, 32'h0000A1A1, 2, 6'd12, "R8 R4 ilv wr beat1");
    step(0, 0, 1, 0, 4'b1111, '0, 32'hB2B20000, 2, 6'd15, "R8 ilv wr beat2");
    step(1, 0, 0, 0, '0, 6'd13, 32'hC3C3C3C3, 1, 6'd13, "R8 readback 13");
    step(1, 0, 0, 0, '0, 6'd12, '0, 1, 6'd12, "R8 readback 12");
    step(1, 0, 0, 0, '0, 6'd15, '0, 1, 6'd15, "R8 readback 15");
    ilv = 0;
  endtask

  task automatic t_desel_adv;
    step(1, 0, 0, 0, '0, 6'd1, '0, 1, 6'd1, "R2 read");
    step(0, 0, 0, 0, '0, 6'd1, '0, 0, '0, "R10 deselect");
    step(1, 0, 1, 0, '0, 6'd3, '0, 0, '0, "R9 adv when idle");
    step(1, 1, 1, 0, '1, 6'd3, '0, 0, '0, "R9 adv write when idle");
    step(1, 0, 0, 0, '0, 6'd3, 32'hFFFFFFFF, 1, 6'd3, "R9 no write done");
  endtask

  task automatic t_oe;
    step(1, 0, 0, 0, '0, 6'd7, '0, 1, 6'd7, "R11 read");
    oe = 0; #1;
    chk(q_drive === 1'b0 && q_data === '0, "R11 oe off", {q_drive, q_data}, '0);
    oe = 1; #1;
    chk(q_drive === 1'b1 && q_data === model[7], "R11 oe on", {q_drive, q_data}, {1'b1, model[7]});
  endtask

  task automatic t_sleep;
    step(1, 1, 0, 1, '1, 6'd4, '0, 0, '0, "R12 sleep write");
    step(1, 0, 0, 1, '0, 6'd4, 32'hDEADBEEF, 0, '0, "R12 sleep read");
    step(1, 0, 0, 0, '0, 6'd4, '0, 1, 6'd4, "R12 data unchanged");
    sleep = 1; #1;
    chk(q_drive === 1'b0, "R12 sleep gates output", {q_drive, q_data}, '0);
    sleep = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk);
    t_reset();
    t_fill();
    t_lanes_bypass();
    t_turnaround();
    t_bursts();
    t_desel_adv();
    t_oe();
    t_sleep();
    step(0, 0, 0, 0, '0, '0, '0, 0, '0, "R10 final idle");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule